// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This unit watches a running calendar and raises a wake interrupt when the present date and time matches a programmed alarm. The calendar fields come in from an external time counter, one byte each. They are packed into two words, a low word and a high word. Each word is compared with a stored alarm word, bit by bit. A mask word decides which bits take part in the match. Clearing a mask bit removes that bit from the comparison, so clearing a whole byte ignores that field.

Software programs the unit through a simple write port. The port carries a small register index, one for each of these registers:

- the control strobes;
- the mode bits;
- the two alarm words;
- the two mask words.

Writing 1 to separate control bits arms or disarms the alarm. Other control bits clear or set the wake condition by hand. The match is evaluated only on the one-second tick. A match latches a pending flag, and raises the interrupt when wake is enabled. In wake-reset mode the unit also sends a one-cycle pulse that asks the time counter to clear.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the outputs armed_o, pending_o, irq_o and time_clr_o are all low, and the alarm, mask and mode registers hold zero.
- R2: A write to index 0 (control) with bit 2 set arms the alarm. A control write with bit 3 set disarms it. When both bits are set, disarm wins. armed_o shows the armed state from the cycle after the write.
- R3: A match is taken only in a cycle where tick_i is high and the alarm was already armed before that clock edge. pending_o rises in the following cycle. Arming in the same cycle as a tick does not match on that tick.
- R4: The match condition is ((current XOR alarm) AND mask) == 0 over both words. The low word packs seconds in bits 7:0, minutes in 15:8, hours in 23:16 and day in 31:24. The high word packs month in 7:0, year in 15:8 and weekday in 23:16, with bits 31:24 of the current value reading as zero. The registers sit at these indices: alarm low 2, alarm high 3, mask low 4, mask high 5.
- R5: Without a tick, or while the alarm is disarmed, no match is taken. This holds even with all-zero alarm and mask registers.
- R6: Mode register (index 1) bit 1 enables wake. A match with wake enabled raises irq_o together with pending_o. A match with wake disabled raises pending_o only.
- R7: pending_o and irq_o hold until cleared. A disarm write clears pending_o, irq_o and armed_o. Control bit 8 (wake clear) clears irq_o only. A disarm written in the same cycle as a matching tick wins over the match.
- R8: Control bit 9 (wake set) raises irq_o without a match. When bits 8 and 9 are written together, the clear wins.
- R9: With mode bit 1 and mode bit 2 (wake reset) set and mode bit 3 (continue) clear, a match pulses time_clr_o high for exactly one cycle, aligned with the rise of pending_o. With mode bit 3 set, no pulse is produced.
- R10: Writes to indices 6 and 7 change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register index |
| wr_data_i | input | 32 | Write data |
| tick_i | input | 1 | One-second tick, one cycle wide |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hour_i | input | 8 | Current hours |
| day_i | input | 8 | Current day of month |
| mon_i | input | 8 | Current month |
| year_i | input | 8 | Current year |
| wday_i | input | 8 | Current weekday |
| irq_o | output | 1 | Wake interrupt |
| pending_o | output | 1 | Alarm match latched |
| armed_o | output | 1 | Alarm armed |
| time_clr_o | output | 1 | One-cycle request to clear the time counter |

## Verification
The hardest situations to reach from the ports are the two collisions between a software write and a matching tick in the same clock cycle:

- a disarm write landing on a matching tick;
- an arm write landing on a tick.

The bench reaches them with a dedicated task that raises tick_i and drives the control write on the same falling edge. Mask coverage comes from several cases:

- a mismatch inside a masked-in field;
- a mismatch inside a masked-out field;
- the weekday lane dropped by the high mask.

## Masked Calendar Alarm Comparator — Trade-offs
// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int FIELD_W = 8;
  localparam int LANE_N  = 4;
  localparam int WORD_W  = FIELD_W * LANE_N;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] IDX_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] IDX_MODE = 3'd1;
  localparam int                IDX_DATA0 = 2;
  localparam int                DATA_REGS = 4;

  localparam int C_ARM      = 2;
  localparam int C_DISARM   = 3;
  localparam int C_WAKE_CLR = 8;
  localparam int C_WAKE_SET = 9;
  localparam int M_WAKE_EN  = 1;
  localparam int M_WAKE_RST = 2;
  localparam int M_CONT     = 3;

  typedef struct packed {
    logic arm;
    logic disarm;
    logic wake_clr;
    logic wake_set;
  } ctrl_s;

  typedef struct packed {
    logic wake_en;
    logic wake_rst;
    logic cont;
  } mode_s;
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [2*DW-1:0] alm_o,
  output logic [2*DW-1:0] msk_o,
  output mode_s         mode_o,
  output ctrl_s         ctrl_o
);
  logic [DW-1:0] data_q [DATA_REGS];
  mode_s         mode_q;

  for (genvar g = 0; g < DATA_REGS; g++) begin : g_data
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(IDX_DATA0 + g)) data_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (wr_en_i && wr_addr_i == IDX_MODE)
      mode_q <= '{wake_en: wr_data_i[M_WAKE_EN], wake_rst: wr_data_i[M_WAKE_RST],
                  cont: wr_data_i[M_CONT]};
  end

  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && wr_addr_i == IDX_CTRL;

  // strobes live only in the write cycle
  assign ctrl_o = '{arm:      ctrl_wr & wr_data_i[C_ARM],
                    disarm:   ctrl_wr & wr_data_i[C_DISARM],
                    wake_clr: ctrl_wr & wr_data_i[C_WAKE_CLR],
                    wake_set: ctrl_wr & wr_data_i[C_WAKE_SET]};

  assign alm_o  = {data_q[1], data_q[0]};
  assign msk_o  = {data_q[3], data_q[2]};
  assign mode_o = mode_q;
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int FW    = FIELD_W,
  parameter int LANES = 2 * LANE_N,
  localparam int VW   = FW * LANES
) (
  input  logic [VW-1:0] cur_i,
  input  logic [VW-1:0] alm_i,
  input  logic [VW-1:0] msk_i,
  output logic          hit_o
);
  logic [LANES-1:0] lane_ok;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ok[g] = ~|((cur_i[g*FW +: FW] ^ alm_i[g*FW +: FW]) & msk_i[g*FW +: FW]);
  end

  assign hit_o = &lane_ok;
endmodule

// File: rtl/cal_alarm_evt.sv
module cal_alarm_evt
  import cal_alarm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  hit_i,
  input  ctrl_s ctrl_i,
  input  mode_s mode_i,
  output logic  armed_o,
  output logic  pending_o,
  output logic  irq_o,
  output logic  time_clr_o
);
  logic armed_q, pend_q, wake_q, clr_q;
  logic match;

  assign match = tick_i & armed_q & hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      wake_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      if (ctrl_i.disarm)   armed_q <= 1'b0;
      else if (ctrl_i.arm) armed_q <= 1'b1;

      if (ctrl_i.disarm)   pend_q <= 1'b0;
      else if (match)      pend_q <= 1'b1;

      // software clear wins over any set in the same cycle
      if (ctrl_i.disarm || ctrl_i.wake_clr)                  wake_q <= 1'b0;
      else if (ctrl_i.wake_set || (match && mode_i.wake_en)) wake_q <= 1'b1;

      clr_q <= match & mode_i.wake_en & mode_i.wake_rst & ~mode_i.cont & ~ctrl_i.disarm;
    end
  end

  assign armed_o    = armed_q;
  assign pending_o  = pend_q;
  assign irq_o      = wake_q;
  assign time_clr_o = clr_q;

  p_disarm_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.disarm |=> !armed_q && !pend_q && !wake_q && !clr_q);

  p_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.arm && !ctrl_i.disarm) |=> armed_q);

  p_pend_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(tick_i && armed_q && hit_i));

  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> $past(ctrl_i.wake_set || (tick_i && armed_q && hit_i && mode_i.wake_en)));

  p_clr_with_pend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> pend_q && !$past(mode_i.cont));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int DW = WORD_W,
  parameter int AW = ADDR_W,
  localparam int VW    = 2 * DW,
  localparam int PAD_W = VW - 7 * FW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          tick_i,
  input  logic [FW-1:0] sec_i,
  input  logic [FW-1:0] min_i,
  input  logic [FW-1:0] hour_i,
  input  logic [FW-1:0] day_i,
  input  logic [FW-1:0] mon_i,
  input  logic [FW-1:0] year_i,
  input  logic [FW-1:0] wday_i,
  output logic          irq_o,
  output logic          pending_o,
  output logic          armed_o,
  output logic          time_clr_o
);
  logic [VW-1:0] alm, msk, cur;
  mode_s         mode;
  ctrl_s         ctrl;
  logic          hit;

  assign cur = {{PAD_W{1'b0}}, wday_i, year_i, mon_i, day_i, hour_i, min_i, sec_i};

  cal_alarm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .alm_o(alm), .msk_o(msk), .mode_o(mode), .ctrl_o(ctrl)
  );

  cal_alarm_cmp #(.FW(FW), .LANES(VW / FW)) u_cmp (
    .cur_i(cur), .alm_i(alm), .msk_i(msk), .hit_o(hit)
  );

  cal_alarm_evt u_evt (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .ctrl_i(ctrl), .mode_i(mode),
    .armed_o, .pending_o, .irq_o, .time_clr_o
  );
endmodule

// File: tb/cal_alarm_match_tb_top.sv
module cal_alarm_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [7:0]  sec = '0, min = '0, hour = '0, day = '0, mon = '0, year = '0, wday = '0;
  logic        irq, pending, armed, time_clr;

  always #4 clk = ~clk;

  cal_alarm_match dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tick_i(tick), .sec_i(sec), .min_i(min), .hour_i(hour), .day_i(day), .mon_i(mon),
    .year_i(year), .wday_i(wday), .irq_o(irq), .pending_o(pending), .armed_o(armed),
    .time_clr_o(time_clr)
  );

  typedef struct { string req; logic [3:0] exp; } item_t;
  item_t q[$];
  event  chk_ev;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  // monitor: compares {armed,pending,irq,time_clr}
  initial begin
    item_t      it;
    logic [3:0] act;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        it  = q.pop_front();
        act = {armed, pending, irq, time_clr};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s act=%b exp=%b", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expect_o(input string req, input logic [3:0] e);
    q.push_back('{req, e});
    -> chk_ev;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick_once;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_o("R1 reset state", 4'b0000);

    sec = 8'h30; min = 8'h15; hour = 8'h09; day = 8'h12;
    mon = 8'h06; year = 8'h24; wday = 8'h03;
    tick_once();
    expect_o("R5 unarmed with zero regs", 4'b0000);

    wr(3'd0, 32'h4);
    expect_o("R2 arm", 4'b1000);
    tick_once();
    expect_o("R3 R6 zero mask matches, no wake", 4'b1100);
    wr(3'd0, 32'h8);
    expect_o("R7 disarm clears", 4'b0000);

    wr(3'd2, 32'h12091530);
    wr(3'd3, 32'h00052406);
    wr(3'd4, 32'hFFFFFFFF);
    wr(3'd5, 32'h0000FFFF);
    wr(3'd1, 32'h2);
    wr(3'd0, 32'h4);
    repeat (3) @(negedge clk);
    expect_o("R5 no tick no match", 4'b1000);
    tick_once();
    expect_o("R4 R6 weekday ignored, wake irq", 4'b1110);
    wr(3'd0, 32'h100);
    expect_o("R7 wake clear keeps pending", 4'b1100);
    wr(3'd0, 32'h8);

    sec = 8'h31;
    wr(3'd0, 32'h4);
    tick_once();
    expect_o("R4 seconds mismatch", 4'b1000);
    sec = 8'h30; mon = 8'h07;
    tick_once();
    expect_o("R4 month mismatch", 4'b1000);
    wr(3'd5, 32'h0000FF00);
    tick_once();
    expect_o("R4 month masked out", 4'b1110);
    wr(3'd0, 32'h8);
    mon = 8'h06;
    wr(3'd5, 32'h0000FFFF);

    wr(3'd0, 32'h200);
    expect_o("R8 wake set", 4'b0010);
    wr(3'd0, 32'h300);
    expect_o("R8 clear beats set", 4'b0000);
    wr(3'd0, 32'hC);
    expect_o("R2 disarm beats arm", 4'b0000);

    wr(3'd1, 32'h6);
    wr(3'd0, 32'h4);
    tick_once();
    expect_o("R9 wake reset pulse", 4'b1111);
    @(negedge clk);
    expect_o("R9 pulse one cycle", 4'b1110);
    wr(3'd0, 32'h8);
    wr(3'd1, 32'hE);
    wr(3'd0, 32'h4);
    tick_once();
    expect_o("R9 continue no pulse", 4'b1110);
    wr(3'd0, 32'h8);

    sec = 8'h31;
    wr(3'd6, 32'h4);
    expect_o("R10 index 6 no arm", 4'b0000);
    wr(3'd7, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd0, 32'h4);
    tick_once();
    expect_o("R10 mask untouched", 4'b1000);
    wr(3'd0, 32'h8);
    sec = 8'h30;

    wr_tick(3'd0, 32'h4);
    expect_o("R3 arm with tick no match", 4'b1000);
    wr_tick(3'd0, 32'h8);
    expect_o("R7 disarm beats match", 4'b0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule